// File: doc/BRIEF.md
# Dual-Bus Ready and Select Controller

This block sits between the pipelined local bus of a 32-bit processor and a 16-bit multiprocessor system bus. It decodes the upper address bits of each cycle and decides whether the cycle belongs to the system bus or to local memory and I/O. A system-bus address window asserts the active-low 16-bit bus-size request and the system-bus enable together, from one decode term. Any other address raises either the local memory select or the local I/O select, depending on the memory/IO indication.

A cycle begins on a clock edge where the active-low address strobe is sampled low. Local cycles then run a wait-state counter. The counter raises one strobe per wait state and pulls the processor's active-low ready low once the parameterised number of waits has elapsed. The first two strobes are also brought out on their own pins so that status lines can be rebuilt from them. System-bus cycles ignore the counter. The asynchronous active-low transfer acknowledge passes through a two-flop synchronizer, and ready pulses low for one clock in the clock after the synchronized acknowledge is seen low. A new address strobe may be accepted in the same clock that ready is low, which keeps the pipelined bus running back to back.

Top module: `dual_bus_ready_ctrl`

## Requirements
- R1: With the decode bits adr_hi (address bits 25 down to 18) equal to 8'b0011_1100, the window F00000h to F3FFFFh, bs16_n is 0 and sysbus_en is 1. They always take opposite values.
- R2: Outside that window bs16_n is 1 and sysbus_en is 0. lmem_sel follows mio (1 = memory) and lio_sel follows its inverse. Exactly one of sysbus_en, lmem_sel and lio_sel is high.
- R3: A local cycle accepted at edge E drives ready_n low for exactly one clock. That clock is the LOCAL_WAITS-th clock after the first data clock, which is the clock that follows E.
- R4: In a local cycle, ws_strobe bit k-1 is high only during the k-th wait-state clock, for k from 1 to LOCAL_WAITS. At most one strobe bit is high at any time, and bits above LOCAL_WAITS never rise.
- R5: ws1 always equals ws_strobe bit 0 and ws2 always equals ws_strobe bit 1.
- R6: With LOCAL_WAITS = 0, ready_n is low in the first data clock and no strobe rises.
- R7: In a system-bus cycle, ready_n stays high until xack_n is low. When xack_n goes low between edges, ready_n goes low in the clock after the third edge that follows, for one clock only.
- R8: No wait-state strobe rises during a system-bus cycle.
- R9: While rst_n is sampled low at an edge, ready_n is high and all strobes are low in the following clock. A cycle in progress is abandoned and produces no ready.
- R10: While no cycle is in progress, ready_n stays high and all strobes stay low.
- R11: An address strobe sampled low in the clock where ready_n is low starts a new cycle at that edge. The new cycle's wait count begins at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ads_n | input | 1 | Active-low address strobe, starts a cycle when sampled low |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| adr_hi | input | DEC_W (8) | Upper address bits 25 down to 18 used by the decode |
| xack_n | input | 1 | Asynchronous active-low transfer acknowledge from the system bus |
| ready_n | output | 1 | Active-low ready to the processor |
| bs16_n | output | 1 | Active-low 16-bit bus-size request |
| sysbus_en | output | 1 | System-bus enable to the bus controller and arbiter |
| lmem_sel | output | 1 | Local memory select |
| lio_sel | output | 1 | Local I/O select |
| ws_strobe | output | NUM_WS (4) | One strobe per local wait state |
| ws1 | output | 1 | First wait-state strobe for status regeneration |
| ws2 | output | 1 | Second wait-state strobe for status regeneration |

## Verification
The bench builds two instances on shared stimulus. The first uses LOCAL_WAITS = 3 and NUM_WS = 4, so three strobes fire in order, the fourth bit must stay low, and a pipelined strobe in the ready clock can be seen restarting the count. The second uses LOCAL_WAITS = 0 and NUM_WS = 2, which exercises the zero-wait path where ready falls in the first data clock. Running both on the same system-bus cycles confirms that the synchronizer latency does not depend on the wait count.

// File: rtl/dbrc_pkg.sv
// Package: shared types for the dual-bus ready controller.
// Assumes: nothing beyond the standard language.
package dbrc_pkg;

    // Kind of bus cycle currently in progress.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_LOCAL = 2'd1,
        CYC_SYS   = 2'd2
    } cyc_kind_t;

endpackage

// File: rtl/dbrc_addr_decode.sv
// Module: dbrc_addr_decode
// Purpose: maps the upper address bits onto the system bus or local selects.
// Assumes: adr_hi is stable while it is used; the output is purely combinational.
module dbrc_addr_decode #(
    parameter int            DEC_W   = 8,
    parameter logic [DEC_W-1:0] SYS_TAG = 8'b0011_1100
) (
    input  logic [DEC_W-1:0] adr_hi,
    input  logic             mio,
    output logic             sys_hit,
    output logic             bs16_n,
    output logic             sysbus_en,
    output logic             lmem_sel,
    output logic             lio_sel
);

    // One match term feeds both system-bus outputs and gates the local selects.
    always_comb begin
        sys_hit   = (adr_hi == SYS_TAG);
        bs16_n    = ~sys_hit;
        sysbus_en = sys_hit;
        lmem_sel  = ~sys_hit & mio;
        lio_sel   = ~sys_hit & ~mio;
    end

endmodule

// File: rtl/dbrc_xack_sync.sv
// Module: dbrc_xack_sync
// Purpose: brings the asynchronous acknowledge into the clock domain.
// Assumes: STAGES >= 2; idle level of the acknowledge is high.
module dbrc_xack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xack_n,
    output logic xack_sync_n
);

    logic [STAGES-1:0] sync_q;

    // Shift the acknowledge through the flop chain, reset to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], xack_n};
        end
    end

    assign xack_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dbrc_wait_seq.sv
// Module: dbrc_wait_seq
// Purpose: counts local wait states, raises one strobe per wait, flags completion.
// Assumes: clear is pulsed at the accepting edge; active is high for a local cycle.
module dbrc_wait_seq #(
    parameter int LOCAL_WAITS = 2,
    parameter int NUM_WS      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    output logic              count_done,
    output logic [NUM_WS-1:0] ws_strobe
);

    localparam int CNT_MAX = (LOCAL_WAITS > NUM_WS) ? LOCAL_WAITS : NUM_WS;
    localparam int CNT_W   = $clog2(CNT_MAX + 2);
    localparam logic [CNT_W-1:0] LW = CNT_W'(LOCAL_WAITS);

    logic [CNT_W-1:0] wcnt;

    // Completion: the count has reached the programmed number of waits.
    assign count_done = active && (wcnt == LW);

    // Advance the count once per clock until the cycle is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (clear) begin
            wcnt <= '0;
        end else if (active && !count_done) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // One strobe per wait state: bit k is high while the count equals k+1.
    for (genvar k = 0; k < NUM_WS; k++) begin : g_strobe
        localparam logic [CNT_W-1:0] STEP = CNT_W'(k + 1);
        if (k < LOCAL_WAITS) begin : g_live
            assign ws_strobe[k] = active && (wcnt == STEP);
        end else begin : g_dead
            assign ws_strobe[k] = 1'b0;
        end
    end

endmodule

// File: rtl/dual_bus_ready_ctrl.sv
// Module: dual_bus_ready_ctrl
// Purpose: top of the controller; decodes each cycle, tracks it, and drives
//          the processor ready from either the local wait count or the
//          synchronized system-bus acknowledge.
// Assumes: adr_hi and mio are valid at the edge where ads_n is sampled low;
//          the acknowledge returns high before the next system-bus cycle.
module dual_bus_ready_ctrl
    import dbrc_pkg::*;
#(
    parameter int               DEC_W       = 8,
    parameter logic [DEC_W-1:0] SYS_TAG     = 8'b0011_1100,
    parameter int               LOCAL_WAITS = 2,
    parameter int               NUM_WS      = 4,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic              mio,
    input  logic [DEC_W-1:0]  adr_hi,
    input  logic              xack_n,
    output logic              ready_n,
    output logic              bs16_n,
    output logic              sysbus_en,
    output logic              lmem_sel,
    output logic              lio_sel,
    output logic [NUM_WS-1:0] ws_strobe,
    output logic              ws1,
    output logic              ws2
);

    cyc_kind_t kind;
    logic      sys_hit;
    logic      xack_sync_n;
    logic      ack_hit;
    logic      local_done;
    logic      ready_now;
    logic      start;

    dbrc_addr_decode #(
        .DEC_W   (DEC_W),
        .SYS_TAG (SYS_TAG)
    ) u_dec (
        .adr_hi    (adr_hi),
        .mio       (mio),
        .sys_hit   (sys_hit),
        .bs16_n    (bs16_n),
        .sysbus_en (sysbus_en),
        .lmem_sel  (lmem_sel),
        .lio_sel   (lio_sel)
    );

    dbrc_xack_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .xack_n      (xack_n),
        .xack_sync_n (xack_sync_n)
    );

    dbrc_wait_seq #(
        .LOCAL_WAITS (LOCAL_WAITS),
        .NUM_WS      (NUM_WS)
    ) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .active     (kind == CYC_LOCAL),
        .count_done (local_done),
        .ws_strobe  (ws_strobe)
    );

    // Ready source: local count or registered acknowledge, by cycle kind.
    always_comb begin
        ready_now = (kind == CYC_LOCAL && local_done) ||
                    (kind == CYC_SYS   && ack_hit);
        ready_n   = ~ready_now;
        start     = ~ads_n && (kind == CYC_IDLE || ready_now);
    end

    // Cycle tracker: open on an accepted strobe, close on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= CYC_IDLE;
        end else if (start) begin
            kind <= sys_hit ? CYC_SYS : CYC_LOCAL;
        end else if (ready_now) begin
            kind <= CYC_IDLE;
        end
    end

    // Acknowledge capture: one clock after the synchronized acknowledge is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_hit <= 1'b0;
        end else if (start || ready_now) begin
            ack_hit <= 1'b0;
        end else if (kind == CYC_SYS && !xack_sync_n) begin
            ack_hit <= 1'b1;
        end
    end

    // Status-regeneration taps on the first two strobes.
    assign ws1 = ws_strobe[0];
    if (NUM_WS >= 2) begin : g_ws2
        assign ws2 = ws_strobe[1];
    end else begin : g_no_ws2
        assign ws2 = 1'b0;
    end

endmodule

// File: rtl/dbrc_checker.sv
// Module: dbrc_checker
// Purpose: temporal checks on the controller, attached by bind.
// Assumes: bound inside dual_bus_ready_ctrl with its internal kind and
//          synchronized acknowledge connected.
module dbrc_checker
    import dbrc_pkg::*;
#(
    parameter int LOCAL_WAITS = 2,
    parameter int NUM_WS      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_n,
    input logic              xack_sync_n,
    input cyc_kind_t         kind,
    input logic              ready_n,
    input logic [NUM_WS-1:0] ws_strobe,
    input logic              bs16_n,
    input logic              sysbus_en,
    input logic              lmem_sel,
    input logic              lio_sel
);

    // R1: size request and enable are always complementary.
    p_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bs16_n != sysbus_en);

    // R2: exactly one destination selected.
    p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sysbus_en, lmem_sel, lio_sel}) == 1);

    // R3: ready lasts one clock unless a new cycle is accepted.
    p_ready_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n && ads_n) |=> ready_n);

    // R4: at most one wait strobe at a time.
    p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ws_strobe));

    // R4: strobes advance in order.
    if (LOCAL_WAITS >= 2 && NUM_WS >= 2) begin : g_order
        p_strobe_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ws_strobe[0] |=> ws_strobe[1]);
    end

    // R7: system-bus ready only after the synchronized acknowledge was low.
    p_xack_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_SYS && !ready_n) |-> ($past(xack_sync_n) == 1'b0));

    // R8: no strobes in a system-bus cycle.
    p_sys_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_SYS) |-> (ws_strobe == '0));

    // R9: reset leaves ready inactive and strobes low.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (ready_n && ws_strobe == '0));

    // R10: idle means no ready and no strobe.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_IDLE) |-> (ready_n && ws_strobe == '0));

endmodule

bind dual_bus_ready_ctrl dbrc_checker #(
    .LOCAL_WAITS (LOCAL_WAITS),
    .NUM_WS      (NUM_WS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ads_n       (ads_n),
    .xack_sync_n (xack_sync_n),
    .kind        (kind),
    .ready_n     (ready_n),
    .ws_strobe   (ws_strobe),
    .bs16_n      (bs16_n),
    .sysbus_en   (sysbus_en),
    .lmem_sel    (lmem_sel),
    .lio_sel     (lio_sel)
);

// File: tb/dual_bus_ready_ctrl_test.sv
// Bench: two instances (3 waits and 0 waits) on shared stimulus.
module dual_bus_ready_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ads_n = 1'b1;
    logic       mio = 1'b1;
    logic [7:0] adr_hi = 8'h00;
    logic       xack_n = 1'b1;

    logic       rdy_a, bs_a, en_a, lm_a, li_a, w1_a, w2_a;
    logic [3:0] ws_a;
    logic       rdy_z, bs_z, en_z, lm_z, li_z, w1_z, w2_z;
    logic [1:0] ws_z;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_bus_ready_ctrl #(.LOCAL_WAITS(3), .NUM_WS(4)) uut (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .adr_hi(adr_hi),
        .xack_n(xack_n), .ready_n(rdy_a), .bs16_n(bs_a), .sysbus_en(en_a),
        .lmem_sel(lm_a), .lio_sel(li_a), .ws_strobe(ws_a), .ws1(w1_a), .ws2(w2_a)
    );

    dual_bus_ready_ctrl #(.LOCAL_WAITS(0), .NUM_WS(2)) uut_z (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .adr_hi(adr_hi),
        .xack_n(xack_n), .ready_n(rdy_z), .bs16_n(bs_z), .sysbus_en(en_z),
        .lmem_sel(lm_z), .lio_sel(li_z), .ws_strobe(ws_z), .ws1(w1_z), .ws2(w2_z)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Decode vectors: {expected system hit, mio, address bits 25..18}.
    localparam logic [9:0] DEC_VEC [10] = '{
        {1'b1, 1'b1, 8'h3C},   // F00000h
        {1'b1, 1'b1, 8'h3C},   // F3FFFFh, same tag
        {1'b0, 1'b1, 8'h3B},   // EFFFFFh just below
        {1'b0, 1'b1, 8'h3D},   // F40000h just above
        {1'b0, 1'b1, 8'h7C},   // A24 set
        {1'b0, 1'b0, 8'hBC},   // A25 set, I/O
        {1'b1, 1'b0, 8'h3C},   // window with I/O indication
        {1'b0, 1'b0, 8'h00},   // low I/O
        {1'b0, 1'b1, 8'hFF},   // top of space
        {1'b0, 1'b1, 8'h3E}    // A19 set
    };

    // Start one cycle: strobe low across one edge, return in the first data clock.
    task automatic begin_cycle(input logic [7:0] a, input logic m);
        @(negedge clk);
        adr_hi = a; mio = m; ads_n = 1'b0;
        @(negedge clk);
        ads_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R9) and idle (R10).
        repeat (3) @(negedge clk);
        chk("R9 ready_n in reset", 32'(rdy_a), 32'd1);
        chk("R9 strobes in reset", 32'(ws_a), 32'd0);
        chk("R9 zero-wait ready_n in reset", 32'(rdy_z), 32'd1);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 idle ready_n", 32'(rdy_a), 32'd1);
            chk("R10 idle strobes", 32'(ws_a), 32'd0);
            chk("R10 idle zero-wait ready_n", 32'(rdy_z), 32'd1);
        end

        // Decode table walk (R1, R2).
        for (int i = 0; i < 10; i++) begin
            adr_hi = DEC_VEC[i][7:0];
            mio    = DEC_VEC[i][8];
            #1;
            chk("R1 bs16_n", 32'(bs_a), 32'(!DEC_VEC[i][9]));
            chk("R1 sysbus_en", 32'(en_a), 32'(DEC_VEC[i][9]));
            chk("R2 lmem_sel", 32'(lm_a), 32'(!DEC_VEC[i][9] && DEC_VEC[i][8]));
            chk("R2 lio_sel", 32'(li_a), 32'(!DEC_VEC[i][9] && !DEC_VEC[i][8]));
        end

        // Local memory cycle: R3, R4, R5 on uut, R6 on uut_z.
        begin_cycle(8'h01, 1'b1);
        for (int k = 0; k < 5; k++) begin
            chk("R3 local ready_n", 32'(rdy_a), (k == 3) ? 32'd0 : 32'd1);
            chk("R4 local strobes", 32'(ws_a),
                (k >= 1 && k <= 3) ? 32'(1 << (k - 1)) : 32'd0);
            chk("R5 ws1 tap", 32'(w1_a), 32'(k == 1));
            chk("R5 ws2 tap", 32'(w2_a), 32'(k == 2));
            chk("R6 zero-wait ready_n", 32'(rdy_z), (k == 0) ? 32'd0 : 32'd1);
            chk("R6 zero-wait strobes", 32'(ws_z), 32'd0);
            @(negedge clk);
        end

        // Local I/O cycle also counts waits (R3).
        begin_cycle(8'h00, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 local I/O ready_n", 32'(rdy_a), 32'd0);
        @(negedge clk);
        chk("R3 local I/O ready released", 32'(rdy_a), 32'd1);

        // System-bus cycle: R7, R8 on both instances.
        begin_cycle(8'h3C, 1'b1);
        for (int k = 0; k < 5; k++) begin
            chk("R7 sys ready_n before xack", 32'(rdy_a), 32'd1);
            chk("R7 sys zero-wait ready_n before xack", 32'(rdy_z), 32'd1);
            chk("R8 sys strobes", 32'(ws_a), 32'd0);
            @(negedge clk);
        end
        xack_n = 1'b0;
        @(negedge clk);
        chk("R7 ready_n after 1 edge", 32'(rdy_a), 32'd1);
        @(negedge clk);
        chk("R7 ready_n after 2 edges", 32'(rdy_a), 32'd1);
        @(negedge clk);
        chk("R7 ready_n after 3 edges", 32'(rdy_a), 32'd0);
        chk("R7 zero-wait ready_n after 3 edges", 32'(rdy_z), 32'd0);
        @(negedge clk);
        chk("R7 ready_n one clock only", 32'(rdy_a), 32'd1);
        chk("R7 zero-wait ready_n one clock only", 32'(rdy_z), 32'd1);
        xack_n = 1'b1;
        repeat (4) @(negedge clk);

        // Pipelined start in the ready clock (R11).
        begin_cycle(8'h02, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 first cycle ready", 32'(rdy_a), 32'd0);
        adr_hi = 8'h03; ads_n = 1'b0;
        @(negedge clk);
        ads_n = 1'b1;
        chk("R11 new cycle first data clock ready_n", 32'(rdy_a), 32'd1);
        chk("R11 new cycle count restarted", 32'(ws_a), 32'd0);
        @(negedge clk);
        chk("R11 new cycle first wait", 32'(ws_a), 32'd1);
        repeat (2) @(negedge clk);
        chk("R11 new cycle ready", 32'(rdy_a), 32'd0);
        repeat (2) @(negedge clk);

        // Reset during a local cycle (R9).
        begin_cycle(8'h04, 1'b1);
        @(negedge clk);
        chk("R9 pre-reset first wait", 32'(ws_a), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 ready_n after reset edge", 32'(rdy_a), 32'd1);
        chk("R9 strobes after reset edge", 32'(ws_a), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 abandoned cycle gives no ready", 32'(rdy_a), 32'd1);
            chk("R10 strobes stay low", 32'(ws_a), 32'd0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule